// File: doc/BRIEF.md
# Reconfigurable Four-Input Lookup Cell with Shift-Register Mode

This block is a four-input lookup cell built around one 16-bit single-bit-per-entry store. In lookup mode, the four select inputs form an address, and a tree of 2-to-1 multiplexers drives the stored bit at that address straight to the output. The same store can also act as a clocked shift register whose tap is chosen by the select inputs. In that mode a serial bit enters entry 0 on each enabled edge. The bit that falls off the top entry is brought out so that cells can be chained.

The whole truth table can be written in one cycle through a parallel configuration port. Each cell also has its own output flip-flop, as in a logic slice. A select input picks either the registered or the combinational value for the cell output. A single synchronous reset clears the store and the flip-flop.

Top module: `cfg_lut_cell`

## Requirements
- R1: The combinational output equals store entry `sel`, where `sel` is read as an unsigned binary index (bit 3 most significant) and entry index k is bit k of the store.
- R2: When `cfg_load` is high on a rising edge, all 16 store bits take the value of `cfg_data` (bit k to entry k).
- R3: When `shift_mode` is 1, `shift_en` is 1 and `cfg_load` is 0 on a rising edge, entry k takes the old entry k-1 for k from 1 to 15, and entry 0 takes `ser_in`.
- R4: When `cfg_load` and an enabled shift occur together, the load wins and the store equals `cfg_data`.
- R5: When `shift_mode` is 0, `shift_en` and `ser_in` have no effect on the store.
- R6: When `shift_mode` is 1 and `shift_en` is 0 (no load), the store holds.
- R7: `cascade_out` always shows store entry 15, so after an enabled shift it shows the old entry 14.
- R8: The output flip-flop captures the combinational lookup value on every rising edge. A synchronous `rst` clears the flip-flop and the store to 0.
- R9: With `reg_sel` = 1, `lut_out` shows the flip-flop. With `reg_sel` = 0, it shows the combinational lookup value.
- R10: With the table loaded as 16'h05C1, the cell outputs 1 exactly for the `sel` values 0, 6, 7, 8 and 10, and 0 for the other eleven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Parallel table write strobe |
| cfg_data | input | 16 | Table contents to write |
| shift_mode | input | 1 | 1 selects shift-register mode, 0 selects plain lookup mode |
| shift_en | input | 1 | Shift enable, used only in shift mode |
| ser_in | input | 1 | Serial bit shifted into entry 0 |
| sel | input | 4 | Lookup address / tap select |
| reg_sel | input | 1 | 1 selects the registered output |
| lut_out | output | 1 | Cell output |
| cascade_out | output | 1 | Store entry 15, for chaining cells |

## Verification
A wrong store bit can stay hidden until `sel` points at it. The bench therefore compares the combinational output against its own table model on every cycle, with random addresses, so a corrupted entry shows up as soon as it is addressed. A bad shift or a load that loses priority also shows on `cascade_out` within one cycle, because that port exposes the top entry at all times. A flip-flop fault appears one edge later, in any cycle where `reg_sel` is high.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

  localparam int LUT_ADDR_W = 4;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } store_op_e;

  // A parallel write outranks a shift; a shift needs both mode and enable.
  function automatic store_op_e decode_op(input logic load,
                                          input logic mode,
                                          input logic en);
    if (load)             return OP_LOAD;
    else if (mode && en)  return OP_SHIFT;
    else                  return OP_HOLD;
  endfunction

endpackage

// File: rtl/lut_bit_store.sv
module lut_bit_store
  import lut_cell_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  store_op_e        op,
  input  logic             ser_in,
  input  logic [DEPTH-1:0] cfg_data,
  output logic [DEPTH-1:0] store_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
    end else begin
      unique case (op)
        OP_LOAD:  store_q <= cfg_data;
        OP_SHIFT: store_q <= {store_q[DEPTH-2:0], ser_in};
        default:  store_q <= store_q;
      endcase
    end
  end

endmodule

// File: rtl/lut_tap_mux.sv
module lut_tap_mux #(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [DEPTH-1:0]  leaves,
  input  logic [ADDR_W-1:0] sel,
  output logic              picked
);

  // Level 0 holds the leaves; level d halves level d-1 using sel[d-1].
  for (genvar d = 0; d <= ADDR_W; d++) begin : g_lvl
    logic [(DEPTH >> d)-1:0] v;
    if (d == 0) begin : g_leaf
      assign v = leaves;
    end else begin : g_node
      for (genvar j = 0; j < (DEPTH >> d); j++) begin : g_j
        assign v[j] = sel[d-1] ? g_lvl[d-1].v[2*j+1] : g_lvl[d-1].v[2*j];
      end
    end
  end

  assign picked = g_lvl[ADDR_W].v[0];

endmodule

// File: rtl/lut_out_stage.sv
module lut_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic comb_bit,
  input  logic reg_sel,
  output logic q_reg,
  output logic out_bit
);

  always_ff @(posedge clk) begin
    if (rst) q_reg <= 1'b0;
    else     q_reg <= comb_bit;
  end

  assign out_bit = reg_sel ? q_reg : comb_bit;

endmodule

// File: rtl/cfg_lut_cell.sv
module cfg_lut_cell
  import lut_cell_pkg::*;
#(
  parameter int ADDR_W = LUT_ADDR_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [DEPTH-1:0]  cfg_data,
  input  logic              shift_mode,
  input  logic              shift_en,
  input  logic              ser_in,
  input  logic [ADDR_W-1:0] sel,
  input  logic              reg_sel,
  output logic              lut_out,
  output logic              cascade_out
);

  store_op_e        op;
  logic [DEPTH-1:0] store_bits;
  logic             comb_bit;
  logic             q_reg;
  logic             shift_fire;
  logic             load_fire;

  assign op         = decode_op(cfg_load, shift_mode, shift_en);
  assign shift_fire = (op == OP_SHIFT);
  assign load_fire  = (op == OP_LOAD);

  lut_bit_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .ser_in   (ser_in),
    .cfg_data (cfg_data),
    .store_q  (store_bits)
  );

  lut_tap_mux #(.ADDR_W(ADDR_W)) u_mux (
    .leaves (store_bits),
    .sel    (sel),
    .picked (comb_bit)
  );

  lut_out_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .comb_bit (comb_bit),
    .reg_sel  (reg_sel),
    .q_reg    (q_reg),
    .out_bit  (lut_out)
  );

  assign cascade_out = store_bits[DEPTH-1];

endmodule

// File: rtl/cfg_lut_cell_chk.sv
module cfg_lut_cell_chk #(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_load,
  input logic [DEPTH-1:0]  cfg_data,
  input logic              shift_mode,
  input logic              shift_en,
  input logic              ser_in,
  input logic              cascade_out,
  input logic [DEPTH-1:0]  store_bits,
  input logic              comb_bit,
  input logic              q_reg,
  input logic              shift_fire,
  input logic              load_fire
);

  AST_LOAD_WRITES: assert property (@(posedge clk) disable iff (rst)
    load_fire |=> store_bits == $past(cfg_data));  // R2

  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (rst)
    shift_fire |=> store_bits == {$past(store_bits[DEPTH-2:0]), $past(ser_in)});  // R3

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (cfg_load && shift_mode && shift_en) |=> store_bits == $past(cfg_data));  // R4

  AST_LOGIC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cfg_load && !shift_mode) |=> $stable(store_bits));  // R5

  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!cfg_load && shift_mode && !shift_en) |=> $stable(store_bits));  // R6

  AST_CASCADE_STEP: assert property (@(posedge clk) disable iff (rst)
    shift_fire |=> cascade_out == $past(store_bits[DEPTH-2]));  // R7

  AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> q_reg == $past(comb_bit));  // R8

endmodule

bind cfg_lut_cell cfg_lut_cell_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_load    (cfg_load),
  .cfg_data    (cfg_data),
  .shift_mode  (shift_mode),
  .shift_en    (shift_en),
  .ser_in      (ser_in),
  .cascade_out (cascade_out),
  .store_bits  (store_bits),
  .comb_bit    (comb_bit),
  .q_reg       (q_reg),
  .shift_fire  (shift_fire),
  .load_fire   (load_fire)
);

// File: tb/cfg_lut_cell_test.sv
module cfg_lut_cell_test;

  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_load = 1'b0;
  logic [N-1:0]  cfg_data = '0;
  logic          shift_mode = 1'b0;
  logic          shift_en = 1'b0;
  logic          ser_in = 1'b0;
  logic [3:0]    sel = '0;
  logic          reg_sel = 1'b0;
  logic          lut_out;
  logic          cascade_out;

  int checks = 0;
  int fails  = 0;

  logic [N-1:0] m_store = '0;
  logic         m_q = 1'b0;

  always #10 clk = ~clk;

  cfg_lut_cell uut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_data(cfg_data),
    .shift_mode(shift_mode), .shift_en(shift_en), .ser_in(ser_in),
    .sel(sel), .reg_sel(reg_sel), .lut_out(lut_out), .cascade_out(cascade_out)
  );

  // Table lookup restated as a bit scan rather than an index.
  function automatic logic ref_lookup(input logic [N-1:0] t, input logic [3:0] a);
    logic r = 1'b0;
    for (int k = 0; k < N; k++) if (k == int'(a)) r = t[k];
    return r;
  endfunction

  function automatic logic [N-1:0] ref_next(input logic [N-1:0] t, input logic r,
      input logic ld, input logic [N-1:0] d, input logic md, input logic en,
      input logic s);
    logic [N-1:0] n;
    if (r) return '0;
    if (ld) return d;
    if (!(md && en)) return t;
    n[0] = s;
    for (int k = 1; k < N; k++) n[k] = t[k-1];
    return n;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b (sel=%0d store model=%h)",
               tag, act, exp, sel, m_store);
    end
  endtask

  // Drive after the falling edge, check the outputs, then move the model across the rising edge.
  task automatic cycle(input logic r, input logic ld, input logic [N-1:0] d,
      input logic md, input logic en, input logic s, input logic [3:0] a,
      input logic rs, input string tag);
    logic [N-1:0] nxt;
    logic         qn;
    @(negedge clk);
    rst = r; cfg_load = ld; cfg_data = d; shift_mode = md;
    shift_en = en; ser_in = s; sel = a; reg_sel = rs;
    #2;
    check(lut_out, rs ? m_q : ref_lookup(m_store, a), tag);
    check(cascade_out, m_store[N-1], {tag, " R7 cascade"});
    nxt = ref_next(m_store, r, ld, d, md, en, s);
    qn  = r ? 1'b0 : ref_lookup(m_store, a);
    @(posedge clk);
    #1;
    m_store = nxt;
    m_q     = qn;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1D5EED);

    // Reset state, R8
    cycle(1, 0, '0, 0, 0, 0, 4'd0, 0, "R8 reset");
    cycle(1, 0, '0, 0, 0, 0, 4'd3, 1, "R8 reset");
    cycle(0, 0, '0, 0, 0, 0, 4'd0, 1, "R8 reset reg");

    // Example table, R2 and R10
    cycle(0, 1, 16'h05C1, 0, 0, 0, 4'd0, 0, "R2 load");
    for (int a = 0; a < N; a++) cycle(0, 0, '0, 0, 0, 0, 4'(a), 0, "R10 R1 sweep");
    for (int a = 0; a < N; a++) cycle(0, 0, '0, 0, 0, 0, 4'(a), 1, "R10 R9 reg sweep");

    // Shift enable and serial input ignored in lookup mode, R5
    for (int i = 0; i < 6; i++) cycle(0, 0, '0, 0, 1, 1'(i), 4'(i), 0, "R5 logic hold");
    for (int a = 0; a < N; a++) cycle(0, 0, '0, 0, 1, 1, 4'(a), 0, "R5 contents");

    // Shift mode idle, R6
    for (int i = 0; i < 4; i++) cycle(0, 0, '0, 1, 0, 1, 4'(15 - i), 0, "R6 idle");

    // Walk a single 1 up the chain to the cascade, R3 and R7
    cycle(0, 1, '0, 0, 0, 0, 4'd0, 0, "R2 clear");
    cycle(0, 0, '0, 1, 1, 1, 4'd0, 0, "R3 shift in");
    for (int i = 0; i < 16; i++) cycle(0, 0, '0, 1, 1, 0, 4'(i + 1), 0, "R3 R7 walk");

    // Load against an enabled shift, R4
    cycle(0, 1, 16'hA5A5, 1, 1, 1, 4'd1, 0, "R4 prio");
    for (int a = 0; a < N; a++) cycle(0, 0, '0, 0, 0, 0, 4'(a), 0, "R4 contents");

    // Reset mid-operation clears store and flip-flop, R8
    cycle(1, 0, '0, 1, 1, 1, 4'd0, 1, "R8 midreset");
    cycle(0, 0, '0, 0, 0, 0, 4'd5, 1, "R8 after reset");

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic r  = ($urandom % 200) == 0;
      logic ld = ($urandom % 10) == 0;
      cycle(r, ld, N'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            4'($urandom), 1'($urandom), "R1 R3 R8 R9 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule